// File: doc/BRIEF.md
# Debug Status and Control Register

This block is the status and control register of a processor debug unit. It holds a single word that software or an external debugger reads and writes through a simple port with select, write and user-mode qualifiers. The stored control fields decide whether halting or monitor debugging is active, whether interrupts reach the core, whether the debug-acknowledge output is forced, whether user-mode software may touch the debug registers, and whether asynchronous aborts are forwarded or quietly recorded in a sticky flag.

An external debug-enable input masks the two debug-mode enables without losing what was written to them. Debug-state entry and exit pulses from the core track debug state. They also set and clear the abort-discard control by hardware. Raw IRQ/FIQ inputs pass through a gate, and the asynchronous-abort event is either forwarded or absorbed.

Top module: `dbgCtlReg`

## Requirements
- R1: After reset every stored field, the sticky abort flag and the debug state are 0, so the register reads 0x00000000, the debug-acknowledge output is low and no debug mode is indicated.
- R2: A write (select and write high, not refused by R5) stores bits 19, 15, 14, 13, 12, 11 and 10 of the write data on the next rising clock edge. The read data is combinational from stored state. Bits 18 to 16, bit 9 and every bit other than these and bit 6 always read 0, and writing them has no effect.
- R3: While the debug-enable input is low, bits 15 and 14 read 0 and neither mode is indicated. Their stored value is kept and is visible and effective again as soon as the input is high.
- R4: Halting mode is indicated when bit 14 is effectively set. Monitor mode is indicated only when bit 15 is effectively set and bit 14 is not.
- R5: A selected access with the user-mode qualifier high while bit 12 is 1 drives the undefined-access output high in that cycle, and its write is ignored. Accesses without the qualifier are never refused.
- R6: While bit 11 is 1 the IRQ and FIQ outputs are low. Otherwise they follow their inputs combinationally.
- R7: The debug-acknowledge output is high when the core is in debug state or bit 10 is 1. An entry pulse sets debug state and an exit pulse clears it on the next edge. Entry wins when both are high.
- R8: An entry pulse sets bit 19 and an exit pulse clears it on the next edge. This hardware update overrides a software write to bit 19 in the same cycle, and entry wins over exit.
- R9: While bit 19 is 0 the abort-forward output equals the asynchronous-abort input. While it is 1 the output stays low and the abort sets the sticky flag, read at bit 6, on the next edge.
- R10: Writing 1 to bit 6 clears the sticky flag and writing 0 leaves it unchanged. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | Register access select |
| regWr | input | 1 | Access is a write |
| regUser | input | 1 | Access comes from user mode |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data, combinational |
| regUndef | output | 1 | Undefined-access error for a refused user access |
| dbgEnable | input | 1 | External debug enable |
| enterDbg | input | 1 | Debug-state entry pulse |
| exitDbg | input | 1 | Debug-state exit pulse |
| asyncAbort | input | 1 | Asynchronous abort event |
| irqIn | input | 1 | Raw IRQ |
| fiqIn | input | 1 | Raw FIQ |
| irqOut | output | 1 | Gated IRQ |
| fiqOut | output | 1 | Gated FIQ |
| dbgAckOut | output | 1 | Debug acknowledge |
| abortFwd | output | 1 | Forwarded asynchronous abort |
| modeHalt | output | 1 | Halting debug mode is in effect |
| modeMon | output | 1 | Monitor debug mode is in effect |

## Verification
The embedded properties assume that every input is driven to a known level after reset. They also assume that the entry and exit indications are sampled only at rising edges, so a one-cycle pulse acts exactly once. The stimulus changes all inputs on the falling edge only and drives every one of them in every cycle, with entry, exit and abort events drawn at low rates so that single pulses, back-to-back pulses and simultaneous entry/exit all occur. Directed cycles force the collisions that random draws reach rarely: a software write to bit 19 together with a hardware update, an abort together with a sticky clear, and mode writes made while debug enable is low.

// File: rtl/dbgCtlRegPkg.sv
package dbgCtlRegPkg;
  // Field positions inside the register word
  localparam int unsigned DISCARD_BIT = 19;
  localparam int unsigned MON_BIT     = 15;
  localparam int unsigned HALT_BIT    = 14;
  localparam int unsigned EXEC_BIT    = 13;
  localparam int unsigned USERDIS_BIT = 12;
  localparam int unsigned INTDIS_BIT  = 11;
  localparam int unsigned ACKFRC_BIT  = 10;
  localparam int unsigned STICKY_BIT  = 6;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic wrEn;        // accepted software write
    logic stickySet;   // discarded abort
    logic stickyClr;   // write-one-to-clear of the sticky flag
    logic discardSet;  // debug-state entry
    logic discardClr;  // debug-state exit
  } ctlStrobes_t;
endpackage

// File: rtl/dbgCtlRegCtrl.sv
module dbgCtlRegCtrl
  import dbgCtlRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWr,
  input  logic        regUser,
  input  logic        wdSticky,
  input  logic        enterDbg,
  input  logic        exitDbg,
  input  logic        asyncAbort,
  input  logic        userDisQ,
  input  logic        discardQ,
  output ctlStrobes_t strb,
  output logic        inDebug,
  output logic        regUndef,
  output logic        abortFwd
);

  logic refuse;

  always_comb begin
    refuse         = regSel && regUser && userDisQ;
    regUndef       = refuse;
    strb.wrEn      = regSel && regWr && !refuse;
    strb.stickyClr = strb.wrEn && wdSticky;
    strb.stickySet = asyncAbort && discardQ;
    strb.discardSet = enterDbg;
    strb.discardClr = exitDbg && !enterDbg;
    abortFwd       = asyncAbort && !discardQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         inDebug <= 1'b0;
    else if (enterDbg) inDebug <= 1'b1;
    else if (exitDbg)  inDebug <= 1'b0;
  end

  // R7
  enter_sets_debug_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterDbg |=> inDebug);

  // R7
  exit_clears_debug_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exitDbg && !enterDbg) |=> !inDebug);

  // R8
  enter_sets_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    enterDbg |=> discardQ);

  // R8
  exit_clears_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exitDbg && !enterDbg) |=> !discardQ);

  // R5
  refused_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regUndef && !enterDbg && !exitDbg) |=> ($stable(userDisQ) && $stable(discardQ)));

endmodule

// File: rtl/dbgCtlRegDp.sv
module dbgCtlRegDp
  import dbgCtlRegPkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              dbgEnable,
  input  logic              irqIn,
  input  logic              fiqIn,
  input  logic              inDebug,
  output logic [DATA_W-1:0] regRdata,
  output logic              userDisQ,
  output logic              discardQ,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              dbgAckOut,
  output logic              modeHalt,
  output logic              modeMon
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] WR_MASK =
    (ONE << DISCARD_BIT) | (ONE << MON_BIT) | (ONE << HALT_BIT) |
    (ONE << EXEC_BIT) | (ONE << USERDIS_BIT) | (ONE << INTDIS_BIT) |
    (ONE << ACKFRC_BIT);
  localparam logic [DATA_W-1:0] MODE_MASK = (ONE << MON_BIT) | (ONE << HALT_BIT);

  logic [DATA_W-1:0] ctlQ, ctlD, hideMask;
  logic              stickyQ, stickyD;
  logic              haltEff, monEff;

  always_comb begin
    ctlD = strb.wrEn ? (regWdata & WR_MASK) : ctlQ;
    if (strb.discardSet)      ctlD[DISCARD_BIT] = 1'b1;
    else if (strb.discardClr) ctlD[DISCARD_BIT] = 1'b0;
    stickyD = strb.stickySet || (stickyQ && !strb.stickyClr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ    <= '0;
      stickyQ <= 1'b0;
    end else begin
      ctlQ    <= ctlD;
      stickyQ <= stickyD;
    end
  end

  always_comb begin
    hideMask = dbgEnable ? '0 : MODE_MASK;
    regRdata = (ctlQ & ~hideMask) | (stickyQ ? (ONE << STICKY_BIT) : '0);
    haltEff  = ctlQ[HALT_BIT] && dbgEnable;
    monEff   = ctlQ[MON_BIT] && dbgEnable;
    modeHalt = haltEff;
    modeMon  = monEff && !haltEff;
    userDisQ = ctlQ[USERDIS_BIT];
    discardQ = ctlQ[DISCARD_BIT];
    irqOut   = irqIn && !ctlQ[INTDIS_BIT];
    fiqOut   = fiqIn && !ctlQ[INTDIS_BIT];
    dbgAckOut = inDebug || ctlQ[ACKFRC_BIT];
  end

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> (regRdata[EXEC_BIT:ACKFRC_BIT] == $past(regWdata[EXEC_BIT:ACKFRC_BIT])));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[18:16] == 3'b000) && !regRdata[9]);

  // R3
  mask_modes_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dbgEnable |-> (!modeHalt && !modeMon));

  // R4
  halt_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(modeHalt && modeMon));

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stickySet |=> regRdata[STICKY_BIT]);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[STICKY_BIT] && !strb.stickyClr) |=> regRdata[STICKY_BIT]);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.wrEn) && $past(regWdata[INTDIS_BIT])) |-> (!irqOut && !fiqOut));

endmodule

// File: rtl/dbgCtlReg.sv
module dbgCtlReg
  import dbgCtlRegPkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regUser,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regUndef,
  input  logic              dbgEnable,
  input  logic              enterDbg,
  input  logic              exitDbg,
  input  logic              asyncAbort,
  input  logic              irqIn,
  input  logic              fiqIn,
  output logic              irqOut,
  output logic              fiqOut,
  output logic              dbgAckOut,
  output logic              abortFwd,
  output logic              modeHalt,
  output logic              modeMon
);

  ctlStrobes_t strb;
  logic        inDebug, userDisQ, discardQ;

  dbgCtlRegCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regSel     (regSel),
    .regWr      (regWr),
    .regUser    (regUser),
    .wdSticky   (regWdata[STICKY_BIT]),
    .enterDbg   (enterDbg),
    .exitDbg    (exitDbg),
    .asyncAbort (asyncAbort),
    .userDisQ   (userDisQ),
    .discardQ   (discardQ),
    .strb       (strb),
    .inDebug    (inDebug),
    .regUndef   (regUndef),
    .abortFwd   (abortFwd)
  );

  dbgCtlRegDp #(.DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWdata  (regWdata),
    .dbgEnable (dbgEnable),
    .irqIn     (irqIn),
    .fiqIn     (fiqIn),
    .inDebug   (inDebug),
    .regRdata  (regRdata),
    .userDisQ  (userDisQ),
    .discardQ  (discardQ),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut),
    .dbgAckOut (dbgAckOut),
    .modeHalt  (modeHalt),
    .modeMon   (modeMon)
  );

endmodule

// File: tb/test_dbgCtlReg.sv
module test_dbgCtlReg;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam logic [31:0] MASK = 32'h000F_FC00 & ~32'h0007_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 0, regWr = 0, regUser = 0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic regUndef, dbgEnable = 0, enterDbg = 0, exitDbg = 0, asyncAbort = 0;
  logic irqIn = 0, fiqIn = 0, irqOut, fiqOut, dbgAckOut, abortFwd, modeHalt, modeMon;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [31:0] mCtl = '0;
  logic mSticky = 0, mDbg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgCtlReg #(.DATA_W(DATA_W)) i_dbgCtlReg (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regUser(regUser),
    .regWdata(regWdata), .regRdata(regRdata), .regUndef(regUndef),
    .dbgEnable(dbgEnable), .enterDbg(enterDbg), .exitDbg(exitDbg),
    .asyncAbort(asyncAbort), .irqIn(irqIn), .fiqIn(fiqIn), .irqOut(irqOut),
    .fiqOut(fiqOut), .dbgAckOut(dbgAckOut), .abortFwd(abortFwd),
    .modeHalt(modeHalt), .modeMon(modeMon));

  function automatic logic [31:0] expView();
    logic [31:0] v;
    v = mCtl;
    if (!dbgEnable) begin v[15] = 1'b0; v[14] = 1'b0; end
    v[6] = mSticky;
    return v;
  endfunction

  function automatic logic expUndef();
    return regSel && regUser && mCtl[12];
  endfunction

  function automatic logic expHalt();
    return mCtl[14] && dbgEnable;
  endfunction

  function automatic logic expMon();
    return mCtl[15] && dbgEnable && !mCtl[14];
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
  endtask

  // Caller sets inputs right after a falling edge, then calls step.
  task automatic step();
    logic wrOk;
    logic [31:0] nCtl;
    #2;
    check("R2", "read data", regRdata, expView());
    check("R5", "undef", {31'b0, regUndef}, {31'b0, expUndef()});
    check("R6", "irq", {31'b0, irqOut}, {31'b0, irqIn && !mCtl[11]});
    check("R6", "fiq", {31'b0, fiqOut}, {31'b0, fiqIn && !mCtl[11]});
    check("R7", "ack", {31'b0, dbgAckOut}, {31'b0, mDbg || mCtl[10]});
    check("R9", "abort fwd", {31'b0, abortFwd}, {31'b0, asyncAbort && !mCtl[19]});
    check("R4", "halt", {31'b0, modeHalt}, {31'b0, expHalt()});
    check("R4", "mon", {31'b0, modeMon}, {31'b0, expMon()});
    @(posedge clk);
    wrOk = regSel && regWr && !expUndef();
    nCtl = wrOk ? (regWdata & MASK) : mCtl;
    if (enterDbg) nCtl[19] = 1'b1;
    else if (exitDbg) nCtl[19] = 1'b0;
    mSticky = (asyncAbort && mCtl[19]) || (mSticky && !(wrOk && regWdata[6]));
    mDbg = enterDbg ? 1'b1 : (exitDbg ? 1'b0 : mDbg);
    mCtl = nCtl;
    @(negedge clk);
  endtask

  task automatic idle();
    regSel = 0; regWr = 0; regUser = 0; regWdata = '0;
    enterDbg = 0; exitDbg = 0; asyncAbort = 0;
  endtask

  task automatic wr(logic [31:0] d);
    idle(); regSel = 1; regWr = 1; regWdata = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    irqIn = 1; fiqIn = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check("R1", "reset read", regRdata, 32'h0);
    check("R1", "reset ack", {31'b0, dbgAckOut}, 32'h0);
    check("R1", "reset modes", {30'b0, modeHalt, modeMon}, 32'h0);
    dbgEnable = 1;
    step();

    // R2: all-ones write, reserved bits stay 0
    wr(32'hFFFF_FFBF); step(); idle(); step();
    check("R2", "reserved zero", regRdata & 32'h0007_0200, 32'h0);
    // R5: user access refused while bit 12 set, kernel clears
    wr(32'h0); regUser = 1; step();
    wr(32'h0); step(); idle(); step();
    // R3: masked mode write while enable low, then revealed
    dbgEnable = 0; wr(32'h0000_8000); step(); idle(); step();
    check("R3", "hidden mon", {31'b0, regRdata[15]}, 32'h0);
    dbgEnable = 1; step();
    check("R3", "revealed mon", {31'b0, modeMon}, 32'h1);
    // R4: halt wins over monitor
    wr(32'h0000_C000); step(); idle(); step();
    check("R4", "halt priority", {30'b0, modeHalt, modeMon}, 32'h2);
    // R8: entry overrides write of 0 to bit 19
    wr(32'h0); enterDbg = 1; step(); idle(); step();
    check("R8", "entry sets discard", {31'b0, regRdata[19]}, 32'h1);
    // R9 and R10: abort with sticky clear in the same cycle stays set
    idle(); asyncAbort = 1; step();
    wr(32'h0008_0040); asyncAbort = 1; step(); idle(); step();
    check("R10", "set beats clear", {31'b0, regRdata[6]}, 32'h1);
    wr(32'h0008_0000); step(); idle(); step();
    check("R10", "write zero keeps", {31'b0, regRdata[6]}, 32'h1);
    wr(32'h0008_0040); step(); idle(); step();
    check("R10", "w1c clears", {31'b0, regRdata[6]}, 32'h0);
    // R8: exit overrides write of 1; entry wins over exit
    wr(32'h0008_0000); exitDbg = 1; step(); idle(); step();
    check("R8", "exit clears discard", {31'b0, regRdata[19]}, 32'h0);
    idle(); enterDbg = 1; exitDbg = 1; step(); idle(); step();
    check("R7", "entry wins", {31'b0, dbgAckOut}, 32'h1);
    idle(); exitDbg = 1; step();
    // R6: interrupt gating
    wr(32'h0000_0800); step(); idle(); irqIn = 1; fiqIn = 1; step();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      regSel     = ($urandom % 3) == 0;
      regWr      = $urandom % 2;
      regUser    = ($urandom % 4) == 0;
      regWdata   = $urandom;
      dbgEnable  = ($urandom % 5) != 0;
      enterDbg   = ($urandom % 12) == 0;
      exitDbg    = ($urandom % 12) == 0;
      asyncAbort = ($urandom % 4) == 0;
      irqIn      = $urandom % 2;
      fiqIn      = $urandom % 2;
      step();
    end

    summary();
    $finish;
  end
endmodule